// File: doc/BRIEF.md
# Coefficient Loader for a Multi-Device FIR Filter

This block fills the coefficient store of a FIR filter. Coefficients arrive by one of two routes, and a mode input picks the route. In host mode, single writes from a host pass straight through to the store. In ROM mode, the block reads a byte-wide ROM on its own and writes a complete set of 16-bit coefficients. It can also drive ROMs with a different fixed read latency.

A ROM load starts by itself when reset is released. It can also be started again at any time by pulsing a reload request. Up to sixteen filter instances can share one ROM. Each instance reads its own 256-byte region, chosen by a 4-bit device index. Each coefficient is made from two consecutive bytes, with the low byte first.

While a load runs, the busy flag stays high, and the filter should treat its output as invalid. When the last coefficient has been written, a one-cycle done pulse follows.

Top module: `coef_loader`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `cw_en` and `rom_rd` are all low.
- R2: If `src_rom` is high when reset is released, a full ROM load starts without any request. If `src_rom` is low, no load starts and `busy` stays low.
- R3: During a load, `rom_rd` is high on consecutive cycles. `rom_addr` equals device index × 256 + coefficient number × 2 + byte select (0 = low byte, 1 = high byte), and the bytes are read in ascending order.
- R4: Coefficient k is written to `cw_addr` = k with `cw_data` = {byte at 2k+1, byte at 2k}. All 128 coefficients are written exactly once per load, in ascending order.
- R5: `busy` rises on the cycle after a load starts and stays high through the cycle of the last coefficient write. `rom_rd` and ROM-sourced writes occur only while `busy` is high.
- R6: `done` is a single-cycle pulse on the cycle after the last coefficient write, and `busy` is low in that cycle.
- R7: A `reload_req` pulse in ROM mode starts a fresh full load from the region of the `dev_idx` value sampled with the request. `busy` is high on the next cycle.
- R8: A `reload_req` during a load restarts it from coefficient 0. No write from the abandoned load appears after the request. Only one `done` is issued, for the new load.
- R9: In host mode with the loader idle, `host_we` produces `cw_en` one cycle later, carrying the same address and data. `reload_req` has no effect in host mode.
- R10: In ROM mode, `host_we` is ignored, and no coefficient write results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_rom | input | 1 | Coefficient source: 1 = ROM, 0 = host |
| dev_idx | input | 4 | Device index selecting the ROM region |
| reload_req | input | 1 | Pulse to start or restart a ROM load |
| host_we | input | 1 | Host coefficient write strobe |
| host_addr | input | 7 | Host coefficient number |
| host_data | input | 16 | Host coefficient value |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | 12 | ROM byte address |
| rom_data | input | 8 | ROM read data, valid ROM_LAT cycles after the strobe |
| cw_en | output | 1 | Coefficient write enable toward the filter |
| cw_addr | output | 7 | Coefficient number being written |
| cw_data | output | 16 | Coefficient value being written |
| busy | output | 1 | Load in progress; filter output invalid |
| done | output | 1 | One-cycle pulse after the last coefficient write |

## Verification
The assertions check, on every cycle:
- the outputs are quiet during reset;
- a ROM read never occurs outside busy;
- each read address follows the previous one or restarts at the base of a region;
- done lasts one cycle, follows a write and never overlaps busy;
- a write outside busy can only come from host mode.

The values themselves can only be shown by the bench's scenarios:
- the assembled coefficients, with the low-byte-first packing, in the right region;
- the automatic start at reset release;
- the restart that discards in-flight bytes and begins again at coefficient 0;
- the reload request having no effect in host mode.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_FETCH = 2'd1,
    LD_DRAIN = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cl_rst_sync.sv
module cl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  // asserts at once, releases after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/cl_fetch_seq.sv
module cl_fetch_seq
  import coef_ld_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int RAW   = 8
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               start,
  input  logic [DEV_W-1:0]   dev_idx,
  input  logic               last_wr,
  output logic               rom_rd,
  output logic [DEV_W+RAW-1:0] rom_addr,
  output logic [RAW-1:0]     issue_idx,
  output logic               busy,
  output logic               done
);
  localparam logic [RAW-1:0] IDX_LAST = '1;

  ld_state_e        state_q, state_n;
  logic [RAW-1:0]   cnt_q, cnt_n;
  logic [DEV_W-1:0] dev_q;
  logic             fin_q, fin_n;
  logic             done_q, done_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    fin_n   = 1'b0;
    done_n  = 1'b0;
    if (start) begin
      state_n = LD_FETCH;
      cnt_n   = '0;
    end else begin
      fin_n = last_wr;
      case (state_q)
        LD_FETCH: begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == IDX_LAST) state_n = LD_DRAIN;
        end
        LD_DRAIN: begin
          if (fin_q) begin
            state_n = LD_IDLE;
            done_n  = 1'b1;
          end
        end
        default: state_n = LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= LD_IDLE;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      fin_q   <= fin_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    dev_q <= '0;
    else if (start) dev_q <= dev_idx;
  end

  assign rom_rd    = (state_q == LD_FETCH);
  assign rom_addr  = {dev_q, cnt_q};
  assign issue_idx = cnt_q;
  assign busy      = (state_q != LD_IDLE);
  assign done      = done_q;
endmodule

// File: rtl/cl_byte_pack.sv
module cl_byte_pack #(
  parameter int RAW    = 8,
  parameter int LAT    = 2,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_sn,
  input  logic                flush,
  input  logic                issue_v,
  input  logic [RAW-1:0]      issue_idx,
  input  logic [BYTE_W-1:0]   rom_data,
  output logic                wr_v,
  output logic [RAW-2:0]      wr_idx,
  output logic [2*BYTE_W-1:0] wr_data,
  output logic                wr_last
);
  // one stage per cycle of ROM latency, each carrying the byte index
  for (genvar k = 0; k < LAT; k++) begin : g_stg
    logic           v_in, v_q;
    logic [RAW-1:0] t_in, t_q;
    if (k == 0) begin : g_head
      assign v_in = issue_v;
      assign t_in = issue_idx;
    end else begin : g_link
      assign v_in = g_stg[k-1].v_q;
      assign t_in = g_stg[k-1].t_q;
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) v_q <= 1'b0;
      else         v_q <= v_in & ~flush;
    end

    always_ff @(posedge clk) begin
      if (v_in) t_q <= t_in;
    end
  end

  logic              arrive;
  logic [RAW-1:0]    arr_tag;
  logic [BYTE_W-1:0] lo_q;

  assign arrive  = g_stg[LAT-1].v_q & ~flush;
  assign arr_tag = g_stg[LAT-1].t_q;

  always_ff @(posedge clk) begin
    if (arrive && !arr_tag[0]) lo_q <= rom_data;
  end

  assign wr_v    = arrive & arr_tag[0];
  assign wr_idx  = arr_tag[RAW-1:1];
  assign wr_data = {rom_data, lo_q};
  assign wr_last = &arr_tag[RAW-1:1];
endmodule

// File: rtl/cl_write_port.sv
module cl_write_port #(
  parameter int CIDX_W = 7,
  parameter int COEF_W = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              busy,
  input  logic              src_rom,
  input  logic              host_we,
  input  logic [CIDX_W-1:0] host_addr,
  input  logic [COEF_W-1:0] host_data,
  input  logic              rom_wv,
  input  logic [CIDX_W-1:0] rom_widx,
  input  logic [COEF_W-1:0] rom_wdata,
  output logic              cw_en,
  output logic [CIDX_W-1:0] cw_addr,
  output logic [COEF_W-1:0] cw_data
);
  logic host_ok;
  assign host_ok = host_we & ~src_rom & ~busy;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) cw_en <= 1'b0;
    else         cw_en <= rom_wv | host_ok;
  end

  always_ff @(posedge clk) begin
    if (rom_wv) begin
      cw_addr <= rom_widx;
      cw_data <= rom_wdata;
    end else if (host_ok) begin
      cw_addr <= host_addr;
      cw_data <= host_data;
    end
  end
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int NUM_COEF = 128,
  parameter int COEF_W   = 16,
  parameter int DEV_W    = 4,
  parameter int ROM_LAT  = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             src_rom,
  input  logic [DEV_W-1:0]                 dev_idx,
  input  logic                             reload_req,
  input  logic                             host_we,
  input  logic [$clog2(NUM_COEF)-1:0]      host_addr,
  input  logic [COEF_W-1:0]                host_data,
  output logic                             rom_rd,
  output logic [DEV_W+$clog2(NUM_COEF):0]  rom_addr,
  input  logic [COEF_W/2-1:0]              rom_data,
  output logic                             cw_en,
  output logic [$clog2(NUM_COEF)-1:0]      cw_addr,
  output logic [COEF_W-1:0]                cw_data,
  output logic                             busy,
  output logic                             done
);
  localparam int CIDX_W = $clog2(NUM_COEF);
  localparam int RAW    = CIDX_W + 1;
  localparam int BYTE_W = COEF_W / 2;

  logic rst_sn;
  logic boot_q;
  logic start;

  logic              wr_v, wr_last;
  logic [CIDX_W-1:0] wr_idx;
  logic [COEF_W-1:0] wr_data;
  logic [RAW-1:0]    issue_idx;

  cl_rst_sync #(.STAGES(2)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // set by reset, cleared at the first edge after release
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     boot_q <= 1'b1;
    else if (boot_q) boot_q <= 1'b0;
  end

  assign start = src_rom & (boot_q | reload_req);

  cl_fetch_seq #(.DEV_W(DEV_W), .RAW(RAW)) u_seq (
    .clk(clk), .rst_sn(rst_sn), .start(start), .dev_idx(dev_idx),
    .last_wr(wr_v & wr_last), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .issue_idx(issue_idx), .busy(busy), .done(done)
  );

  cl_byte_pack #(.RAW(RAW), .LAT(ROM_LAT), .BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_sn(rst_sn), .flush(start), .issue_v(rom_rd),
    .issue_idx(issue_idx), .rom_data(rom_data), .wr_v(wr_v),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_last(wr_last)
  );

  cl_write_port #(.CIDX_W(CIDX_W), .COEF_W(COEF_W)) u_wport (
    .clk(clk), .rst_sn(rst_sn), .busy(busy), .src_rom(src_rom),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .rom_wv(wr_v), .rom_widx(wr_idx), .rom_wdata(wr_data),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data)
  );
endmodule

// File: rtl/cl_loader_chk.sv
module cl_loader_chk #(
  parameter int AW  = 12,
  parameter int RAW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          src_rom,
  input logic          rom_rd,
  input logic [AW-1:0] rom_addr,
  input logic          cw_en,
  input logic          busy,
  input logic          done
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!busy && !done && !cw_en && !rom_rd); // R1
  end

  AST_BOOT_FROM_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(src_rom)); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && $past(rom_rd)) |->
      ((rom_addr == $past(rom_addr) + 1'b1) || (rom_addr[RAW-1:0] == '0))); // R3

  AST_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> busy); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(cw_en))); // R6

  AST_IDLE_WRITE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_en && !busy) |-> !$past(src_rom)); // R10
endmodule

bind coef_loader cl_loader_chk #(
  .AW(DEV_W + $clog2(NUM_COEF) + 1),
  .RAW($clog2(NUM_COEF) + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_rom(src_rom), .rom_rd(rom_rd),
  .rom_addr(rom_addr), .cw_en(cw_en), .busy(busy), .done(done)
);

// File: tb/coef_loader_test.sv
module coef_loader_test;
  logic        clk;
  logic        rst_n;
  logic        src_rom;
  logic [3:0]  dev_idx;
  logic        reload_req;
  logic        host_we;
  logic [6:0]  host_addr;
  logic [15:0] host_data;
  logic        rom_rd;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data;
  logic        cw_en;
  logic [6:0]  cw_addr;
  logic [15:0] cw_data;
  logic        busy;
  logic        done;

  int checks = 0;
  int errors = 0;

  coef_loader uut (
    .clk(clk), .rst_n(rst_n), .src_rom(src_rom), .dev_idx(dev_idx),
    .reload_req(reload_req), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .rom_data(rom_data), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ROM model: data appears two cycles after the read strobe
  function automatic logic [7:0] rbyte(input logic [11:0] a);
    logic [19:0] m;
    m = 20'(a) * 20'd37;
    return m[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  logic [11:0] p1, p2;
  always @(posedge clk) begin
    p1 <= rom_addr;
    p2 <= p1;
  end
  assign rom_data = rbyte(p2);

  // observer, sampling at the falling edge
  logic [15:0] shadow [128];
  int  wr_cnt, done_cnt, addr_err, seq_err, order_err, zero_err, rd_cnt;
  bit  expect_zero;
  logic [3:0]  cur_dev;
  logic        prev_rd;
  logic [11:0] prev_addr;
  int          last_widx;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cw_en) begin
        shadow[cw_addr] = cw_data;
        wr_cnt++;
        if (expect_zero) begin
          if (cw_addr != 7'd0) zero_err++;
          expect_zero = 1'b0;
        end else if (src_rom && int'(cw_addr) != last_widx + 1) order_err++;
        last_widx = int'(cw_addr);
      end
      if (done) done_cnt++;
      if (rom_rd) begin
        rd_cnt++;
        if (rom_addr[11:8] != cur_dev) addr_err++;
        if (prev_rd && rom_addr != prev_addr + 12'd1 && rom_addr[7:0] != 8'd0) seq_err++;
      end
      prev_rd   = rom_rd;
      prev_addr = rom_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_obs(input logic [3:0] dev);
    for (int i = 0; i < 128; i++) shadow[i] = 16'hDEAD;
    wr_cnt = 0; done_cnt = 0; addr_err = 0; seq_err = 0; order_err = 0;
    zero_err = 0; rd_cnt = 0; expect_zero = 1'b0; prev_rd = 1'b0;
    prev_addr = '0; last_widx = -1; cur_dev = dev;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(busy == 1'b0, "R6", "busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done one cycle", done, 0);
  endtask

  task automatic check_set(input logic [3:0] dev, input string req);
    int bad = 0;
    logic [15:0] exp;
    for (int k = 0; k < 128; k++) begin
      exp = {rbyte({dev, 7'(k), 1'b1}), rbyte({dev, 7'(k), 1'b0})};
      if (shadow[k] != exp) begin
        if (bad == 0) chk(1'b0, req, $sformatf("coef %0d", k), shadow[k], exp);
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, "coef set", 0, 0);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; src_rom = mode; reload_req = 1'b0; host_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cw_en && !rom_rd, "R1", "outputs quiet in reset",
        {busy, done, cw_en, rom_rd}, 0);
  endtask

  task automatic t_boot_rom();
    dev_idx = 4'd3;
    clear_obs(4'd3);
    do_reset(1'b1);
    rst_n = 1'b1;
    wait_done("R2");
    chk(wr_cnt == 128, "R4", "write count", wr_cnt, 128);
    chk(order_err == 0, "R4", "ascending order", order_err, 0);
    check_set(4'd3, "R4");
    chk(rd_cnt == 256, "R3", "read count", rd_cnt, 256);
    chk(addr_err == 0 && seq_err == 0, "R3", "address pattern", addr_err + seq_err, 0);
    chk(done_cnt == 1, "R6", "done count", done_cnt, 1);
  endtask

  task automatic t_reload();
    clear_obs(4'd15);
    dev_idx = 4'd15; reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0; dev_idx = 4'd0;
    chk(busy == 1'b1, "R7", "busy after request", busy, 1);
    chk(rom_rd == 1'b1, "R5", "reading while busy", rom_rd, 1);
    wait_done("R7");
    check_set(4'd15, "R7");
    chk(addr_err == 0, "R7", "region of sampled index", addr_err, 0);
  endtask

  task automatic t_restart();
    clear_obs(4'd5);
    dev_idx = 4'd5; reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy == 1'b1, "R5", "busy mid load", busy, 1);
    dev_idx = 4'd9; reload_req = 1'b1; cur_dev = 4'd9;
    @(negedge clk);
    reload_req = 1'b0; expect_zero = 1'b1;
    for (int i = 0; i < 128; i++) shadow[i] = 16'hDEAD;
    wait_done("R8");
    chk(zero_err == 0, "R8", "restart at coefficient 0", zero_err, 0);
    check_set(4'd9, "R8");
    chk(done_cnt == 1, "R8", "single done", done_cnt, 1);
  endtask

  task automatic t_host_in_rom();
    clear_obs(4'd0);
    host_we = 1'b1; host_addr = 7'd12; host_data = 16'h1234;
    @(negedge clk);
    host_we = 1'b0;
    chk(cw_en == 1'b0, "R10", "host write ignored", cw_en, 0);
    @(negedge clk);
    chk(wr_cnt == 0, "R10", "no write", wr_cnt, 0);
  endtask

  task automatic t_host_mode();
    clear_obs(4'd0);
    do_reset(1'b0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(busy == 1'b0 && rd_cnt == 0, "R2", "no load in host mode", busy, 0);
    for (int i = 0; i < 3; i++) begin
      host_we = 1'b1; host_addr = 7'(i * 45 + 3); host_data = 16'(16'hA5C3 ^ (i * 16'h1111));
      @(negedge clk);
      host_we = 1'b0;
      chk(cw_en == 1'b1, "R9", "host write enable", cw_en, 1);
      chk(cw_addr == 7'(i * 45 + 3), "R9", "host write addr", cw_addr, i * 45 + 3);
      chk(cw_data == 16'(16'hA5C3 ^ (i * 16'h1111)), "R9", "host write data",
          cw_data, 16'hA5C3 ^ (i * 16'h1111));
    end
    reload_req = 1'b1; dev_idx = 4'd2;
    @(negedge clk);
    reload_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && rd_cnt == 0, "R9", "request ignored in host mode", rd_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_rom = 1'b1; dev_idx = '0; reload_req = 1'b0;
    host_we = 1'b0; host_addr = '0; host_data = '0;
    @(negedge clk);
    t_boot_rom();
    t_reload();
    t_restart();
    t_host_in_rom();
    t_host_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule